// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 65,536 words of 16 bits. The requester presents one word-sized read or write at a time on a valid/ready handshake. The controller turns each request into a timed pin sequence. It drives an active-low chip select, write strobe and output enable, a per-byte lane enable vector and the 16-bit word address. It also controls the direction of the shared data bus, which is split here into an output, an output enable and an input so that the pad cell can sit outside the block.

The number of clock cycles that the strobe or output enable is held is derived from the clock period and the RAM's 15 ns address-to-data time, rounded up. A write places address, lanes and data one cycle before the strobe falls and keeps them one cycle after it rises. A read holds the enables for the wait count and samples the bus at the end of the last cycle. Read lanes that were not requested come back as zero.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, and whenever `req_ready` is high, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is all ones, `mem_dq_oe` is 0 and `rsp_valid` is 0 outside a response.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the sequence ends, and with `req_valid` low no pin leaves its idle level.
- R3: In a write, `mem_ce_n` is low with address, lanes and data driven for one cycle before `mem_we_n` falls. `mem_we_n` stays low for exactly WAIT cycles. For one cycle after it rises, chip select, address, lanes and data are unchanged.
- R4: Request mask bit 0 selects the lower lane (data bits 7:0) and drives `mem_be_n[0]` low. Mask bit 1 selects the upper lane (bits 15:8) and drives `mem_be_n[1]` low, so a write changes only the masked bytes of the word.
- R5: In a read, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` high for exactly WAIT cycles. `rsp_valid` is high for one cycle, the cycle in which `mem_oe_n` has just returned high, carrying the bus value from the last enabled cycle.
- R6: In `rsp_rdata`, any lane whose mask bit was 0 reads as zero, whatever the bus carried.
- R7: `mem_dq_oe` is high only during a write sequence. It is never high while `mem_oe_n` is low, and it has been low for at least one full cycle before `mem_oe_n` falls.
- R8: WAIT equals the ceiling of TAA_PS / CLK_PS, with a minimum of 1. The defaults, 15000 ps and 10000 ps, give 2.
- R9: A request with an all-zero mask still runs its full sequence with both lane enables high. Such a write changes no stored byte, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 16 | RAM address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 lower |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_in | input | 16 | Data from the RAM pad |

## Verification
The bench targets three failure modes. The first is a masked write that touches the wrong byte: the word read back then shows a changed neighbour lane. The second is a read that returns stale bus bits on a lane it did not request: the RAM model drives a junk pattern on disabled lanes, so that pattern would leak into `rsp_rdata`. The third is a write followed at once by a read with no bus release in between: the pin monitor would then catch the drive enable high during or right before `mem_oe_n` falling.

The bench also measures strobe and output-enable widths, the one-cycle setup and hold around the write strobe, and the response latency. A wrong WAIT count or a missing hold cycle therefore shows up as a wrong pulse length. Other cases covered are the top address, an all-zero mask, and a request held while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ
  } seq_state_e;

  // Pin-level controls; all strobes active low, drive is the data pad enable.
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  function automatic int wait_cycles(input int clk_ps, input int taa_ps);
    int raw;
    raw = (taa_ps + clk_ps - 1) / clk_ps;
    return (raw < 1) ? 1 : raw;
  endfunction

  function automatic ctl_t ctl_for(input seq_state_e s);
    ctl_t c;
    c = CTL_IDLE;
    case (s)
      ST_SETUP:  begin c.ce_n = 1'b0; c.drive = 1'b1; end
      ST_WPULSE: begin c.ce_n = 1'b0; c.we_n = 1'b0; c.drive = 1'b1; end
      ST_WHOLD:  begin c.ce_n = 1'b0; c.drive = 1'b1; end
      ST_READ:   begin c.ce_n = 1'b0; c.oe_n = 1'b0; end
      default:   c = CTL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WAIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output ctl_t ctl_d
);

  localparam int CW = (WAIT < 2) ? 1 : $clog2(WAIT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          cnt_d   = CNT_LOAD;
          state_d = req_write ? ST_SETUP : ST_READ;
        end
      end
      ST_SETUP: state_d = ST_WPULSE;
      ST_WPULSE: begin
        if (cnt_q == '0) state_d = ST_WHOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WHOLD: state_d = ST_IDLE;
      ST_READ: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ctl_d     = ctl_for(state_d);

  // R2: a taken request always leaves the idle state on the following cycle
  a_r2_leave_idle: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  ctl_t             ctl_d,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_be_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= CTL_IDLE;
      mem_addr   <= '0;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_be_n   <= ~req_be;
        mem_dq_out <= req_wdata;
      end else if (ctl_d.ce_n) begin
        mem_be_n   <= '1;
      end
    end
  end

  assign mem_ce_n  = ctl_q.ce_n;
  assign mem_we_n  = ctl_q.we_n;
  assign mem_oe_n  = ctl_q.oe_n;
  assign mem_dq_oe = ctl_q.drive;

  // R7: pad drive and RAM output enable never overlap
  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  // R7: the pad was released in the cycle before the RAM is allowed to drive
  a_r7_release_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R3: setup cycle precedes the strobe
  a_r3_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $stable(mem_addr) && $stable(mem_be_n)
                        && !$past(mem_ce_n) && $past(mem_dq_oe));

  // R3: hold cycle after the strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_ce_n && mem_dq_oe && $stable(mem_dq_out)
                        && $stable(mem_addr) && $stable(mem_be_n));

  // R3: strobe only inside a selected cycle
  a_r3_we_in_ce: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n && mem_oe_n);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [LANES-1:0] be_n,
  input  logic [DW-1:0]    dq_in,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);

  logic [DW-1:0] masked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = be_n[g] ? 8'h00 : dq_in[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= masked;
    end
  end

  // R5: response is a single-cycle pulse
  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int CLK_PS = 10000,
  parameter int TAA_PS = 15000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [DW/8-1:0]     req_be,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DW/8-1:0]     mem_be_n,
  output logic [DW-1:0]       mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DW-1:0]       mem_dq_in
);

  localparam int LANES = DW / 8;
  localparam int WAIT  = wait_cycles(CLK_PS, TAA_PS);

  logic accept, capture;
  ctl_t ctl_d;

  sram_seq #(.WAIT(WAIT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ctl_d     (ctl_d)
  );

  sram_pin_drv #(.AW(AW), .DW(DW), .LANES(LANES)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .ctl_d      (ctl_d),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(.DW(DW), .LANES(LANES)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .be_n      (mem_be_n),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R1: whenever a new request can be taken, every pin is at its idle level
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe);

  // R5: data is presented exactly as the output enable returns high
  a_r5_resp_align: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(mem_oe_n));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int WAIT_EXP = (15000 + 10000 - 1) / 10000;  // R8: ceil -> 2
  localparam logic [15:0] JUNK = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be    = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_in = JUNK;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // RAM model: stores only enabled lanes, drives junk on lanes it does not drive
  logic [15:0] ram [int];
  function automatic logic [15:0] ram_rd(input logic [15:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
  endfunction

  logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_ce_n = 1'b1, p_oe = 1'b0;
  logic [15:0] p_addr = '0, p_dout = '0;
  logic [1:0]  p_be_n = 2'b11;
  int we_run = 0;
  int oe_run = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // storage side
      if (!mem_ce_n && !mem_we_n) begin
        logic [15:0] w;
        w = ram_rd(mem_addr);
        if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
        if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
        ram[int'(mem_addr)] = w;
      end
      // read side
      begin
        logic [15:0] r;
        r = JUNK;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
          if (!mem_be_n[0]) r[7:0]  = ram_rd(mem_addr) >> 0;
          if (!mem_be_n[1]) r[15:8] = ram_rd(mem_addr) >> 8;
        end
        mem_dq_in = r;
      end
      // pin monitor
      if (!mem_we_n && p_we_n) begin
        check("R3 setup: ce low before strobe", {31'd0, p_ce_n}, 32'd0);
        check("R3 setup: address stable", {16'd0, mem_addr}, {16'd0, p_addr});
        check("R7 drive during write setup", {31'd0, p_oe}, 32'd1);
      end
      if (mem_we_n && !p_we_n) begin
        check("R3/R8 strobe width", we_run, WAIT_EXP);
        check("R3 hold: ce low", {31'd0, mem_ce_n}, 32'd0);
        check("R3 hold: data stable", {16'd0, mem_dq_out}, {16'd0, p_dout});
        check("R3 hold: lanes stable", {30'd0, mem_be_n}, {30'd0, p_be_n});
      end
      if (!mem_oe_n && p_oe_n)
        check("R7 bus released before read", {31'd0, mem_dq_oe | p_oe}, 32'd0);
      if (mem_oe_n && !p_oe_n)
        check("R5 output enable width", oe_run, WAIT_EXP);
      we_run = mem_we_n ? 0 : we_run + 1;
      oe_run = mem_oe_n ? 0 : oe_run + 1;
      p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_ce_n = mem_ce_n; p_oe = mem_dq_oe;
      p_addr = mem_addr; p_dout = mem_dq_out; p_be_n = mem_be_n;
    end
  end

  // Issue one request; for reads, check latency and data (R2, R5, R6)
  task automatic issue(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic [15:0] exp);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 ready low after accept", {31'd0, req_ready}, 32'd0);
    if (!w) begin
      n = 1;
      while (!rsp_valid && n < 20) begin
        @(negedge clk);
        n++;
      end
      check("R5 response latency", n, WAIT_EXP + 1);
      check("R4/R6 read data", {16'd0, rsp_rdata}, {16'd0, exp});
    end
    while (!req_ready) @(negedge clk);
  endtask

  // {write, addr, wdata, mask, expected}
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 16'h0010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 16'h0010, 16'hABCD, 2'b01, 16'h0000},  // R4 lower lane only
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h12CD},
    {1'b1, 16'h0010, 16'h5678, 2'b10, 16'h0000},  // R4 upper lane only
    {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h5600},  // R6 lower masked
    {1'b0, 16'h0010, 16'h0000, 2'b01, 16'h00CD},  // R6 upper masked
    {1'b1, 16'hFFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'hBEEF},
    {1'b1, 16'h0000, 16'h1111, 2'b00, 16'h0000},  // R9 empty write
    {1'b0, 16'h0000, 16'h0000, 2'b11, 16'h0000},
    {1'b0, 16'h0010, 16'h0000, 2'b00, 16'h0000},  // R9 empty read
    {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h56CD}
  };

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: pins during reset
    check("R1 reset pins", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n},
          {27'd0, 5'b11111});
    check("R1 reset drive/rsp", {30'd0, mem_dq_oe, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    // R2: no request, nothing moves
    repeat (4) @(negedge clk);
    check("R2 idle without valid", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd7);

    for (int i = 0; i < NV; i++)
      issue(VEC[i][50], VEC[i][49:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0]);

    // R9: empty write left the model's word untouched (via normal reads above)
    // R2: request held through a busy period is taken once
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020;
    req_wdata = 16'h0F0F; req_be = 2'b11;
    @(negedge clk);
    check("R2 busy after accept", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    // R7: read immediately after a write, bus released in between
    issue(1'b0, 16'h0020, 16'h0000, 2'b11, 16'h0F0F);
    // R1: idle again after the last access
    @(negedge clk);
    check("R1 idle after access", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
          {26'd0, 6'b111110});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule